// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider with Frequency Hopping

This block is the digital side of a frequency synthesizer's divider chain. A modelled 32/33 prescaler counts RF input cycles, which arrive as the `vco_en` enable. A swallow counter steers the modulus: for A prescaler periods the modulus is 33, and for the B periods that follow it is 32. The divider therefore emits one `div_pulse` every N = 33·A + 32·B input cycles.

There are two 24-bit setting words, called main and auxiliary. Each packs A and B. Host writes go into either word at any time. A hop command copies the chosen word into an active set. The swallow counter reloads from that active set only when a divide cycle is complete, so a hop never shortens or stretches the cycle that is running.

A separate reference divider counts ticks of a 20 MHz crystal (`ref_tick`). It produces reference pulses at a rate chosen by a 3-bit code.

Top module: `hop_div_synth`

## Requirements
- R1: With A and B loaded, consecutive `div_pulse` pulses are exactly 33·A + 32·B `vco_en` ticks apart. Each pulse is one clock wide.
- R2: In a written word, bits [9:0] give A and bits [19:10] give B. Bits [23:20] have no effect on the division.
- R3: After each divide boundary, `mod33` is 1 for the first 33·A ticks and 0 for the B periods that follow. When A = 0, `mod33` stays 0.
- R4: Command 0x85 on `cmd` with `cmd_valid` selects the auxiliary word, and `aux_active` reads 1 on the next clock. Command 0x84 selects the main word, and `aux_active` reads 0 on the next clock. Without a command, `aux_active` holds its value.
- R5: Writing either word without a following hop command leaves the output period unchanged. Command codes other than 0x84 and 0x85 are ignored.
- R6: A hop issued partway through a divide cycle lets that cycle finish with its old length. The new N applies from the next cycle.
- R7: `ref_sel` codes 0 to 5 give one `ref_pulse` every 40, 80, 100, 200, 400 or 800 `ref_tick` ticks (500, 250, 200, 100, 50 and 25 kHz). Codes 6 and 7 give 200 ticks (100 kHz).
- R8: After reset, both words and the active set are zero, `aux_active` and `mod33` are 0, and no `div_pulse` occurs. If A = B = 0 is loaded, the divider produces no pulses.
- R9: A `div_pulse` follows only a clock that had `vco_en` high. A `ref_pulse` follows only a clock that had `ref_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_en | input | 1 | One RF input cycle to be counted |
| ref_tick | input | 1 | One 20 MHz crystal cycle |
| wr_main | input | 1 | Write `wr_data` into the main word |
| wr_aux | input | 1 | Write `wr_data` into the auxiliary word |
| wr_data | input | 24 | Setting word: A in [9:0], B in [19:10] |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 8 | Command code (0x84 main, 0x85 auxiliary) |
| ref_sel | input | 3 | Reference rate code |
| div_pulse | output | 1 | One-clock pulse per N counted input cycles |
| mod33 | output | 1 | Prescaler modulus control, 1 = divide by 33 |
| aux_active | output | 1 | Active set was taken from the auxiliary word |
| ref_pulse | output | 1 | One-clock reference-rate pulse |

## Verification
The checker assumes `vco_en`, `ref_tick` and `cmd_valid` are driven to known levels from reset onward. It also assumes every loaded ratio is at least 32, so two divider pulses can never fall on adjacent clocks.

The stimulus respects both assumptions. It holds every input at zero through reset and changes inputs only on the falling edge. It loads only settings with A + B ≥ 1, apart from the deliberate all-zero case, and that case produces no pulses at all.

// File: rtl/hop_div_synth.sv
module hop_div_synth #(
  parameter int FW      = 10,
  parameter int RW      = 24,
  parameter int REF_KHZ = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vco_en,
  input  logic          ref_tick,
  input  logic          wr_main,
  input  logic          wr_aux,
  input  logic [RW-1:0] wr_data,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd,
  input  logic [2:0]    ref_sel,
  output logic          div_pulse,
  output logic          mod33,
  output logic          aux_active,
  output logic          ref_pulse
);
  localparam int AB = 2 * FW;
  localparam logic [7:0] CMD_MAIN = 8'h84;
  localparam logic [7:0] CMD_AUX  = 8'h85;
  localparam int DW = $clog2(REF_KHZ / 25 + 1);

  logic [AB-1:0] main_r, aux_r, act_r;
  logic [FW-1:0] a_left, b_left;
  logic [5:0]    pre_cnt;
  logic [DW-1:0] ref_cnt, ref_last;

  wire          idle      = (a_left == '0) && (b_left == '0);
  wire [FW:0]   left_sum  = {1'b0, a_left} + {1'b0, b_left};
  wire [5:0]    pre_last  = mod33 ? 6'd32 : 6'd31;
  wire          wrap      = vco_en && !idle && (pre_cnt == pre_last);
  wire          done      = wrap && (left_sum == 1);
  wire          ref_wrap  = ref_tick && (ref_cnt >= ref_last);

  assign mod33 = (a_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_r     <= '0;
      aux_r      <= '0;
      act_r      <= '0;
      aux_active <= 1'b0;
    end else begin
      if (wr_main) main_r <= wr_data[AB-1:0];
      if (wr_aux)  aux_r  <= wr_data[AB-1:0];
      if (cmd_valid && cmd == CMD_MAIN) begin
        act_r      <= main_r;
        aux_active <= 1'b0;
      end else if (cmd_valid && cmd == CMD_AUX) begin
        act_r      <= aux_r;
        aux_active <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_left    <= '0;
      b_left    <= '0;
      pre_cnt   <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= done;
      if (idle || done) begin
        a_left  <= act_r[FW-1:0];
        b_left  <= act_r[AB-1:FW];
        pre_cnt <= '0;
      end else if (wrap) begin
        pre_cnt <= '0;
        if (mod33) a_left <= a_left - 1'b1;
        else       b_left <= b_left - 1'b1;
      end else if (vco_en) begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (ref_sel)
      3'd0:    ref_last = DW'(REF_KHZ / 500 - 1);
      3'd1:    ref_last = DW'(REF_KHZ / 250 - 1);
      3'd2:    ref_last = DW'(REF_KHZ / 200 - 1);
      3'd3:    ref_last = DW'(REF_KHZ / 100 - 1);
      3'd4:    ref_last = DW'(REF_KHZ / 50 - 1);
      3'd5:    ref_last = DW'(REF_KHZ / 25 - 1);
      default: ref_last = DW'(REF_KHZ / 100 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt   <= '0;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= ref_wrap;
      if (ref_wrap)      ref_cnt <= '0;
      else if (ref_tick) ref_cnt <= ref_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hop_div_synth_chk.sv
module hop_div_synth_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vco_en,
  input logic       ref_tick,
  input logic       cmd_valid,
  input logic [7:0] cmd,
  input logic       div_pulse,
  input logic       ref_pulse,
  input logic       aux_active
);
  a_r1_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  a_r7_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);
  a_r9_div_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vco_en) |-> !div_pulse);
  a_r9_ref_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ref_tick) |-> !ref_pulse);
  a_r4_hop_aux: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 8'h85) |=> aux_active);
  a_r4_hop_main: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 8'h84) |=> !aux_active);
  a_r4_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(aux_active));
endmodule

bind hop_div_synth hop_div_synth_chk chk_i (.*);

// File: tb/hop_div_synth_tb_top.sv
module hop_div_synth_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vco_en = 1'b0, ref_tick = 1'b0, wr_main = 1'b0, wr_aux = 1'b0;
  logic [23:0] wr_data = '0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd = '0;
  logic [2:0] ref_sel = '0;
  logic div_pulse, mod33, aux_active, ref_pulse;
  logic vco_run = 1'b0, gap_mode = 1'b0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  hop_div_synth dut_i (.*);

  always @(negedge clk) begin
    if (gap_mode) vco_en <= ~vco_en;
    else          vco_en <= vco_run;
  end

  // {word, ref code, expected N, expected ref divisor, A}
  typedef struct packed {
    logic [23:0] word; logic [2:0] sel; int n; int rdiv; int a;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{24'h000001, 3'd0, 33,  40,  1},
    '{24'h000400, 3'd1, 32,  80,  0},
    '{24'h000C02, 3'd2, 162, 100, 2},
    '{24'hF00005, 3'd3, 165, 200, 5},
    '{24'h001000, 3'd4, 128, 400, 0},
    '{24'hA00C03, 3'd5, 195, 800, 3},
    '{24'h000801, 3'd6, 97,  200, 1},
    '{24'h000404, 3'd7, 164, 200, 4}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_div(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!div_pulse && gap < 5000);
  endtask

  task automatic wait_ref(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!ref_pulse && gap < 5000);
  endtask

  task automatic write_word(input logic aux, input logic [23:0] w);
    wr_data = w; wr_main = !aux; wr_aux = aux;
    @(negedge clk);
    wr_main = 1'b0; wr_aux = 1'b0;
  endtask

  task automatic hop(input logic [7:0] c);
    cmd = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    int g, seen;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 aux_active after reset", aux_active, 0);
    chk("R8 mod33 after reset", mod33, 0);
    vco_run = 1'b1;
    seen = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); seen += div_pulse; end
    chk("R8 no pulses from zero set", seen, 0);
    seen = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); seen += ref_pulse; end
    chk("R9 no ref pulse without ref_tick", seen, 0);
    ref_tick = 1'b1;

    foreach (VECS[k]) begin
      logic use_aux;
      use_aux = k[0];
      write_word(use_aux, VECS[k].word);
      hop(use_aux ? 8'h85 : 8'h84);
      chk("R4 aux_active after hop", aux_active, int'(use_aux));
      wait_div(g);
      wait_div(g);
      chk($sformatf("R1 R2 period vec %0d", k), g, VECS[k].n);
      chk("R3 mod33 after boundary", mod33, int'(VECS[k].a != 0));
      if (VECS[k].a != 0 && VECS[k].n != 33 * VECS[k].a) begin
        cyc(33 * VECS[k].a - 1);
        chk("R3 mod33 in last A tick", mod33, 1);
        cyc(1);
        chk("R3 mod33 in B periods", mod33, 0);
      end
      ref_sel = VECS[k].sel;
      wait_ref(g);
      wait_ref(g);
      chk($sformatf("R7 ref divisor code %0d", VECS[k].sel), g, VECS[k].rdiv);
    end

    // Gapped input: one tick every other clock
    write_word(1'b0, 24'h000002);
    hop(8'h84);
    wait_div(g);
    gap_mode = 1'b1;
    wait_div(g);
    wait_div(g);
    chk("R9 R1 gapped ticks period", g, 2 * 66);
    gap_mode = 1'b0; vco_run = 1'b1;
    wait_div(g);

    // Mid-cycle hop: main N=128, aux N=98
    write_word(1'b0, 24'h001000);
    write_word(1'b1, 24'h000402);
    hop(8'h84);
    wait_div(g);
    wait_div(g);
    chk("R1 main set period", g, 128);
    cyc(40);
    hop(8'h85);
    wait_div(g);
    chk("R6 cycle in progress keeps old N", g + 41, 128);
    wait_div(g);
    chk("R6 new N from next cycle", g, 98);

    // Writes without hop, and unknown commands
    write_word(1'b1, 24'h000010);
    wait_div(g);
    wait_div(g);
    chk("R5 active-word rewrite ignored", g, 98);
    hop(8'h86);
    chk("R5 unknown cmd leaves selection", aux_active, 1);
    wait_div(g);
    wait_div(g);
    chk("R5 unknown cmd period", g, 98);
    hop(8'h85);
    wait_div(g);
    wait_div(g);
    chk("R4 re-hop loads rewritten word", g, 528);

    // All-zero setting stops the divider
    write_word(1'b0, 24'h000000);
    hop(8'h84);
    wait_div(g);
    seen = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); seen += div_pulse; end
    chk("R8 zero set gives no pulses", seen, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule